// File: doc/BRIEF.md
# Frequency-Select Strap Capture and Code Source Selector

This block sits in the control domain of a clock generator. While the power-on reset is asserted, five shared pins act as inputs. Their levels, set by board resistors or by internal pull-ups when left open, are sampled into a 5-bit strap register. Once reset is released, the pin-direction control turns the pins into outputs so they can carry clocks. From then on the strap register holds its value, whatever the pins do.

Every control-domain clock, the block presents a registered 5-bit frequency code to the synthesizer. A source-select bit in a software-written control byte chooses where the code comes from: either the captured straps, or a scattered field of that same byte. The same byte also carries a spread-spectrum enable and a global output-disable flag, both of which the block registers. For register readback, the block provides inverted copies of the three upper captured straps.

Top module: `freq_strap_mux`

## Requirements
- R1: The strap register samples `strapPinIn` on every rising clock edge while `pinOutEn` is 0. This covers all edges during reset and the first edge after reset is released. The last sample taken is the captured value.
- R2: `pinOutEn` is 0 while `rstN` is low. It becomes 1 at the first rising edge after `rstN` goes high and stays 1 until the next reset.
- R3: When `ctrlByte` bit 3 is 0, `freqCode` equals the captured straps, with `freqCode[4]` = FS4 down to `freqCode[0]` = FS0. Pins left open read as 1, which gives code 5'b11111.
- R4: When `ctrlByte` bit 3 is 1 and reset is released, `freqCode` is built from bits of `ctrlByte` as follows: `freqCode[4]` = bit 2, `freqCode[3]` = bit 1, `freqCode[2]` = bit 6, `freqCode[1]` = bit 5, `freqCode[0]` = bit 4.
- R5: `spreadEn` follows `ctrlByte` bit 7 and `outTristate` follows `ctrlByte` bit 0, each one clock edge later. Both are 0 while reset is asserted.
- R6: `strapInv[2]` is NOT FS4, `strapInv[1]` is NOT FS3 and `strapInv[0]` is NOT FS2, all taken from the captured straps. These values do not depend on the code source.
- R7: After `pinOutEn` becomes 1, changes on `strapPinIn` have no effect on `freqCode` or `strapInv`.
- R8: `freqCode` changes only at a rising clock edge. A change of `ctrlByte` shows up at the first rising edge after it and never between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| rstN | input | 1 | Power-on reset, active low |
| strapPinIn | input | 5 | Raw levels of the shared strap pins, bit 4 = FS4 … bit 0 = FS0 |
| ctrlByte | input | 8 | Software-written control byte |
| pinOutEn | output | 1 | 1 = shared pins drive clocks, 0 = pins are strap inputs |
| freqCode | output | 5 | Effective registered frequency code |
| strapInv | output | 3 | Inverted captured FS4, FS3, FS2 for readback |
| spreadEn | output | 1 | Spread-spectrum enable |
| outTristate | output | 1 | Disable all clock outputs |

## Verification
The first corner is the reset release edge. A design that stopped sampling one edge early, or kept sampling after the pins turn around, would capture the wrong strap value or track the pins' output activity. The bench therefore toggles the pins after release and expects both the code and the readback to stay frozen.

The scrambled register-field mapping is tested with patterns that separate every bit, so a swapped field position gives a wrong code. The readback must stay inverted and tied to the captured straps while the register source is active; a design that read back the effective code would fail there.

Control-byte changes are checked just before the next edge and just after it. This catches a design that passes the code through combinationally. A second reset with all pins high checks that the straps are captured again with the pulled-up default.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int STRAP_W = 5;
  localparam int BYTE_W  = 8;
  localparam int RDBK_N  = 3;
  localparam int SRC_SEL_BIT = 3;
  localparam int SPREAD_BIT  = 7;
  localparam int TRI_BIT     = 0;

  typedef struct packed {
    logic sampleStraps;
    logic useRegCode;
    logic pinsDrive;
  } fselStrobe_t;

  // Software field placement of the code bits inside the control byte.
  function automatic logic [STRAP_W-1:0] regFieldCode(input logic [BYTE_W-1:0] b);
    return {b[2], b[1], b[6], b[5], b[4]};
  endfunction
endpackage

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] ctrlByte,
  output fselStrobe_t       strb,
  output logic              spreadEn,
  output logic              outTristate
);
  logic releasedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) releasedQ <= 1'b0;
    else       releasedQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spreadEn    <= 1'b0;
      outTristate <= 1'b0;
    end else begin
      spreadEn    <= ctrlByte[SPREAD_BIT];
      outTristate <= ctrlByte[TRI_BIT];
    end
  end

  always_comb begin
    strb.sampleStraps = ~releasedQ;
    strb.pinsDrive    = releasedQ;
    strb.useRegCode   = releasedQ & ctrlByte[SRC_SEL_BIT];
  end

  // R2: pins stay outputs once past the release edge
  assert_pins_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pinsDrive |=> strb.pinsDrive);
  // R2: never sampling and driving at once
  assert_dir_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleStraps != strb.pinsDrive);
  // R5: flags track the byte one edge later
  assert_flags_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pinsDrive |=> (spreadEn == $past(ctrlByte[SPREAD_BIT])) &&
                       (outTristate == $past(ctrlByte[TRI_BIT])));
endmodule

// File: rtl/fsel_datapath.sv
module fsel_datapath
  import fsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  fselStrobe_t        strb,
  input  logic [STRAP_W-1:0] strapPinIn,
  input  logic [BYTE_W-1:0]  ctrlByte,
  output logic [STRAP_W-1:0] freqCode,
  output logic [RDBK_N-1:0]  strapInv
);
  logic [STRAP_W-1:0] strapQ;
  logic [STRAP_W-1:0] regCode;

  assign regCode = regFieldCode(ctrlByte);

  always_ff @(posedge clk) begin
    if (strb.sampleStraps) strapQ <= strapPinIn;
  end

  always_ff @(posedge clk) begin
    freqCode <= strb.useRegCode ? regCode : strapQ;
  end

  for (genvar i = 0; i < RDBK_N; i++) begin : gRdbk
    assign strapInv[i] = ~strapQ[STRAP_W-RDBK_N+i];
  end

  // R7: captured straps frozen once pins drive
  assert_strap_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleStraps |=> $stable(strapQ));
  // R4: register source reaches the code one edge later
  assert_reg_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.useRegCode |=> freqCode == $past(regCode));
  // R3: strap source reaches the code one edge later
  assert_strap_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pinsDrive && !strb.useRegCode) |=> freqCode == $past(strapQ));
endmodule

// File: rtl/freq_strap_mux.sv
module freq_strap_mux
  import fsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapPinIn,
  input  logic [BYTE_W-1:0]  ctrlByte,
  output logic               pinOutEn,
  output logic [STRAP_W-1:0] freqCode,
  output logic [RDBK_N-1:0]  strapInv,
  output logic               spreadEn,
  output logic               outTristate
);
  fselStrobe_t strb;

  fsel_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .strb(strb),
    .spreadEn(spreadEn), .outTristate(outTristate)
  );

  fsel_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .strapPinIn(strapPinIn),
    .ctrlByte(ctrlByte), .freqCode(freqCode), .strapInv(strapInv)
  );

  assign pinOutEn = strb.pinsDrive;
endmodule

// File: tb/freq_strap_mux_test.sv
module freq_strap_mux_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] strapPinIn = 5'b0;
  logic [7:0] ctrlByte = 8'h00;
  logic       pinOutEn, spreadEn, outTristate;
  logic [4:0] freqCode;
  logic [2:0] strapInv;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  freq_strap_mux uut (
    .clk(clk), .rstN(rstN), .strapPinIn(strapPinIn), .ctrlByte(ctrlByte),
    .pinOutEn(pinOutEn), .freqCode(freqCode), .strapInv(strapInv),
    .spreadEn(spreadEn), .outTristate(outTristate)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic [4:0] pins);
    @(negedge clk);
    rstN = 1'b0;
    ctrlByte = 8'h00;
    strapPinIn = pins;
    waitEdges(3);
    check("R2 dir in reset", {7'b0, pinOutEn}, 8'h00);
    check("R5 flags in reset", {6'b0, spreadEn, outTristate}, 8'h00);
    check("R1 code in reset", {3'b0, freqCode}, {3'b0, pins});
    rstN = 1'b1;
    waitEdges(1);
    check("R2 dir after release", {7'b0, pinOutEn}, 8'h01);
    waitEdges(2);
  endtask

  task automatic testCapture;
    doReset(5'b10110);
    check("R3 strap code", {3'b0, freqCode}, 8'h16);
    check("R6 readback", {5'b0, strapInv}, 8'h02);
  endtask

  task automatic testIgnorePins;
    strapPinIn = 5'b01001;
    waitEdges(3);
    strapPinIn = 5'b11111;
    waitEdges(2);
    check("R7 code frozen", {3'b0, freqCode}, 8'h16);
    check("R7 readback frozen", {5'b0, strapInv}, 8'h02);
    check("R2 dir stays", {7'b0, pinOutEn}, 8'h01);
  endtask

  task automatic testRegSource;
    ctrlByte = 8'h5A;               // code 01101
    #1;
    check("R8 no change between edges", {3'b0, freqCode}, 8'h16);
    waitEdges(1);
    check("R4 reg code A", {3'b0, freqCode}, 8'h0D);
    check("R6 readback in reg mode", {5'b0, strapInv}, 8'h02);
    ctrlByte = 8'h2C;               // code 10010
    waitEdges(1);
    check("R4 reg code B", {3'b0, freqCode}, 8'h12);
    ctrlByte = 8'h4E;               // b6,b3,b2,b1 -> 11100
    waitEdges(1);
    check("R4 reg code C", {3'b0, freqCode}, 8'h1C);
    ctrlByte = 8'h00;
    #1;
    check("R8 held before edge", {3'b0, freqCode}, 8'h1C);
    waitEdges(1);
    check("R3 back to straps", {3'b0, freqCode}, 8'h16);
  endtask

  task automatic testFlags;
    ctrlByte = 8'h81;
    #1;
    check("R5 flags wait for edge", {6'b0, spreadEn, outTristate}, 8'h00);
    waitEdges(1);
    check("R5 both flags set", {6'b0, spreadEn, outTristate}, 8'h03);
    check("R3 code under flags", {3'b0, freqCode}, 8'h16);
    ctrlByte = 8'h80;
    waitEdges(1);
    check("R5 spread only", {6'b0, spreadEn, outTristate}, 8'h02);
    ctrlByte = 8'h01;
    waitEdges(1);
    check("R5 tristate only", {6'b0, spreadEn, outTristate}, 8'h01);
    ctrlByte = 8'h00;
    waitEdges(1);
  endtask

  task automatic testPullupDefault;
    doReset(5'b11111);
    check("R3 open pins code", {3'b0, freqCode}, 8'h1F);
    check("R6 open pins readback", {5'b0, strapInv}, 8'h00);
    strapPinIn = 5'b00000;
    waitEdges(2);
    check("R7 after second reset", {3'b0, freqCode}, 8'h1F);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testCapture();
    testIgnorePins();
    testRegSource();
    testFlags();
    testPullupDefault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule